// File: doc/BRIEF.md
# Oversampling serial receiver with per-word error flags

This block turns an asynchronous serial line into data words. An oversample tick, sixteen per bit time, paces it. After a falling edge it confirms the start bit at mid-bit. It recovers every bit by a three-sample majority vote around the bit centre. Bits are shifted in least-significant first. An optional parity bit is checked as odd or even, and one or two stop bits are checked as selected. Each finished word enters a two-entry receive FIFO.

The framing and parity results of a word are stored in the FIFO with that word. They appear on the outputs while that word is at the head.

Overrun and noise are sticky flags. They clear only through a fixed two-step sequence: a status read strobe, then a data read. An interrupt output is gated by an enable. It is raised while a word is waiting or an overrun is pending.

The serial input must already be synchronous to `clk`. The configuration inputs must be held steady while a frame is being received.

Top module: `rxe_uart_rx`

## Requirements
- R1: The FIFO holds up to two words. `data_avail` is high while it holds at least one. `rd_data` shows the oldest word, and is 0 when the FIFO is empty. A one-cycle `data_rd` removes the oldest word. Data bits arrive least significant bit first.
- R2: Each bit is recovered as the majority of the samples taken on oversample ticks 7, 8 and 9 of that bit. Ticks are counted 0 to 15 from the tick that first sees the line low. A single disturbed sample does not change the recovered word.
- R3: A start bit is accepted only if its majority vote is low. If the vote is high, the receiver returns to idle and no word is stored.
- R4: Overrun is an attempt to store a finished word while the FIFO holds two words and no `data_rd` is removing one in the same cycle. On overrun, `ovr_err` sets, the new word is dropped, and the two stored words stay unchanged.
- R5: `noise_err` sets when the three votes of any bit of a frame disagree. This covers the start, data, parity and stop bits. It sets in the same cycle that `data_avail` rises for that word, and the word is still stored.
- R6: `ovr_err` and `noise_err` clear only on a `data_rd` that follows a `stat_rd`, with no other `data_rd` between them. A `data_rd` without a preceding `stat_rd` leaves both flags set. A new set in the same cycle as the clearing read wins.
- R7: `frame_err` is set for a word if its stop bit votes 0. When `cfg_two_stop` is 1, the word gets `frame_err` if either of the two stop bits votes 0.
- R8: When `cfg_par_en` is 1, one parity bit follows the data, and `par_err` is set for a word whose parity does not match. With `cfg_par_odd` at 0, the data plus the parity bit must hold an even number of ones; with it at 1, an odd number. When `cfg_par_en` is 0, no parity bit is expected and `par_err` stays 0.
- R9: `frame_err` and `par_err` belong to the word at the FIFO head and change as words are removed. Both are 0 when the FIFO is empty.
- R10: `irq` equals `rie` AND (`data_avail` OR `ovr_err`). Noise alone raises no interrupt.
- R11: Reset empties the FIFO and clears every flag, the clear sequence and `irq`.
- R12: A word is stored one clock after the tick that takes sample 9 of its last stop bit. After that tick the receiver is idle, and it can detect the next start edge from the following tick on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial data, idle high, synchronous to clk |
| os_tick | input | 1 | Oversample strobe, 16 per bit time |
| cfg_par_en | input | 1 | Expect a parity bit after the data |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one stop bit |
| rie | input | 1 | Receive interrupt enable |
| stat_rd | input | 1 | Status read strobe; arms the flag-clear sequence |
| data_rd | input | 1 | Data read strobe; removes the head word |
| rd_data | output | 8 | Word at the FIFO head |
| data_avail | output | 1 | FIFO not empty |
| ovr_err | output | 1 | Sticky overrun flag |
| noise_err | output | 1 | Sticky noise flag |
| frame_err | output | 1 | Framing error of the head word |
| par_err | output | 1 | Parity error of the head word |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest case to reach is a third word completing while two words sit unread. The bench must then show that the old head word and its flags survive, and that the flag clears only on the correct strobe order. The stimulus gets there by sending three frames back to back with no reads. Next it issues a lone data read, which must leave the overrun flag set. Only then does it issue a status read followed by a data read.

Noise is reached by inverting only sample 8 of one chosen bit. This is done once in a data bit and once in the start bit. The recovered word must come out unchanged while the noise flag rises.

// File: rtl/rxe_pkg.sv
package rxe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // majority of three samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // the three samples do not all agree
  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

  // parity mismatch: red = XOR of data bits, pbit = received parity bit
  function automatic logic par_bad(input logic red, input logic pbit, input logic odd);
    return red ^ pbit ^ odd;
  endfunction

endpackage

// File: rtl/rxe_framer.sv
module rxe_framer
  import rxe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              w_fe,
  output logic              w_pe,
  output logic              w_nz
);
  localparam int CW = $clog2(OSR);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] C_A   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] C_M   = CW'(OSR / 2);
  localparam logic [CW-1:0] C_B   = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] C_END = CW'(OSR - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic              sidx;
  logic              smp_a, smp_m;
  logic [DATA_W-1:0] shreg;
  logic              pbit, nz_acc, fe_acc;

  // named internal events
  logic bit_vote, bit_split, stop_last;
  assign bit_vote  = vote3(smp_a, smp_m, rxd);
  assign bit_split = split3(smp_a, smp_m, rxd);
  assign stop_last = (sidx == two_stop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sidx   <= 1'b0;
      smp_a  <= 1'b1;
      smp_m  <= 1'b1;
      shreg  <= '0;
      pbit   <= 1'b0;
      nz_acc <= 1'b0;
      fe_acc <= 1'b0;
      done   <= 1'b0;
      word   <= '0;
      w_fe   <= 1'b0;
      w_pe   <= 1'b0;
      w_nz   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          if (!rxd) begin
            st     <= ST_START;
            cnt    <= CW'(1);
            bidx   <= '0;
            sidx   <= 1'b0;
            nz_acc <= 1'b0;
            fe_acc <= 1'b0;
          end
        end else begin
          cnt <= (cnt == C_END) ? '0 : cnt + CW'(1);
          if (cnt == C_A) smp_a <= rxd;
          if (cnt == C_M) smp_m <= rxd;
          if (cnt == C_B) begin
            if (bit_split) nz_acc <= 1'b1;
            case (st)
              ST_START: if (bit_vote) st <= ST_IDLE;
              ST_DATA:  shreg <= {bit_vote, shreg[DATA_W-1:1]};
              ST_PAR:   pbit <= bit_vote;
              ST_STOP: begin
                if (!bit_vote) fe_acc <= 1'b1;
                if (stop_last) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
                  word <= shreg;
                  w_fe <= fe_acc | ~bit_vote;
                  w_nz <= nz_acc | bit_split;
                  w_pe <= par_en & par_bad(^shreg, pbit, par_odd);
                end
              end
              default: ;
            endcase
          end
          if (cnt == C_END) begin
            case (st)
              ST_START: st <= ST_DATA;
              ST_DATA: begin
                bidx <= bidx + BW'(1);
                if (bidx == B_LAST) st <= par_en ? ST_PAR : ST_STOP;
              end
              ST_PAR:  st <= ST_STOP;
              ST_STOP: sidx <= 1'b1;
              default: ;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/rxe_fifo.sv
module rxe_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rptr, wptr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign head = mem[rptr];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n)                          mem[g] <= '0;
        else if (push && wptr == PW'(g))     mem[g] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rxe_uart_rx.sv
module rxe_uart_rx
  import rxe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              os_tick,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              rie,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_avail,
  output logic              ovr_err,
  output logic              noise_err,
  output logic              frame_err,
  output logic              par_err,
  output logic              irq
);
  localparam int FW = DATA_W + 2;
  localparam int CW = $clog2(DEPTH + 1);

  logic              f_done, f_fe, f_pe, f_nz;
  logic [DATA_W-1:0] f_word;
  logic [FW-1:0]     head;
  logic [CW-1:0]     fill;

  // named internal events
  logic full, empty, pop, push_ok, ovr_evt, clr_seq, armed;
  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign pop     = data_rd & ~empty;
  assign push_ok = f_done & (~full | pop);
  assign ovr_evt = f_done & full & ~pop;
  assign clr_seq = data_rd & armed;

  rxe_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(os_tick),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .two_stop(cfg_two_stop),
    .done(f_done), .word(f_word), .w_fe(f_fe), .w_pe(f_pe), .w_nz(f_nz)
  );

  rxe_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop),
    .wdata({f_word, f_fe, f_pe}), .head(head), .count(fill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      ovr_err   <= 1'b0;
      noise_err <= 1'b0;
    end else begin
      if (stat_rd)      armed <= 1'b1;
      else if (data_rd) armed <= 1'b0;
      ovr_err   <= ovr_evt | (ovr_err & ~clr_seq);
      noise_err <= (push_ok & f_nz) | (noise_err & ~clr_seq);
    end
  end

  assign {rd_data, frame_err, par_err} = empty ? '0 : head;
  assign data_avail = ~empty;
  assign irq        = rie & (data_avail | ovr_err);

endmodule

// File: rtl/rxe_uart_rx_chk.sv
module rxe_uart_rx_chk #(
  parameter int CW    = 2,
  parameter int DEPTH = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          data_rd,
  input logic          armed,
  input logic          push_ok,
  input logic          ovr_evt,
  input logic          data_avail,
  input logic          ovr_err,
  input logic          noise_err,
  input logic          frame_err,
  input logic          par_err,
  input logic          irq,
  input logic          rie,
  input logic [CW-1:0] fill
);
  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH)); // R1
  AST_AVAIL_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> data_avail); // R1
  AST_OVR_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $past(fill) == CW'(DEPTH)); // R4
  AST_OVR_KEEPS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> fill == CW'(DEPTH)); // R4
  AST_NOISE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noise_err) |-> $past(push_ok)); // R5
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && !(data_rd && armed)) |=> ovr_err); // R6
  AST_NOISE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_err && !(data_rd && armed)) |=> noise_err); // R6
  AST_FLAGS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail |-> (!frame_err && !par_err)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !rie |-> !irq); // R10
  AST_NOISE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_avail && !ovr_err) |-> !irq); // R10
endmodule

bind rxe_uart_rx rxe_uart_rx_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .armed(armed),
  .push_ok(push_ok), .ovr_evt(ovr_evt), .data_avail(data_avail),
  .ovr_err(ovr_err), .noise_err(noise_err), .frame_err(frame_err),
  .par_err(par_err), .irq(irq), .rie(rie), .fill(fill)
);

// File: tb/tb_rxe_uart_rx.sv
module tb_rxe_uart_rx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, os_tick = 1'b0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic rie = 1'b0, stat_rd = 1'b0, data_rd = 1'b0;
  logic [7:0] rd_data;
  logic data_avail, ovr_err, noise_err, frame_err, par_err, irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxe_uart_rx dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .rie(rie), .stat_rd(stat_rd), .data_rd(data_rd), .rd_data(rd_data),
    .data_avail(data_avail), .ovr_err(ovr_err), .noise_err(noise_err),
    .frame_err(frame_err), .par_err(par_err), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: word queue plus sticky flags
  int qd[$];
  bit qf[$];
  bit qp[$];
  bit m_ovr, m_nz, m_arm;
  bit push_req = 0;
  int push_d;
  bit push_fe, push_pe, push_nz;

  always @(posedge clk) begin : model
    bit clr, so, sn;
    if (!rst_n) begin
      qd.delete(); qf.delete(); qp.delete();
      m_ovr = 0; m_nz = 0; m_arm = 0;
    end else begin
      clr = data_rd && m_arm;
      so = 0; sn = 0;
      if (data_rd && qd.size() > 0) begin
        void'(qd.pop_front()); void'(qf.pop_front()); void'(qp.pop_front());
      end
      if (push_req) begin
        if (qd.size() < 2) begin
          qd.push_back(push_d); qf.push_back(push_fe); qp.push_back(push_pe);
          sn = push_nz;
        end else so = 1;
      end
      m_ovr = so | (m_ovr & !clr);
      m_nz  = sn | (m_nz & !clr);
      if (stat_rd) m_arm = 1;
      else if (data_rd) m_arm = 0;
    end
  end

  // compare every clock, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD / 4);
    if (cmp_on) begin
      bit e;
      e = qd.size() > 0;
      chk("R1 R12 data_avail", data_avail, e);
      chk("R1 rd_data", rd_data, e ? qd[0] : 0);
      chk("R9 frame_err", frame_err, e ? qf[0] : 0);
      chk("R9 par_err", par_err, e ? qp[0] : 0);
      chk("R4 ovr_err", ovr_err, m_ovr);
      chk("R5 noise_err", noise_err, m_nz);
      chk("R10 irq", irq, rie && (e || m_ovr));
    end
  end

  task automatic samp(input logic v, input bit last);
    @(negedge clk); rxd = v; os_tick = 1'b1;
    @(negedge clk); os_tick = 1'b0; if (last) push_req = 1;
    @(negedge clk); push_req = 0;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_s1,
                            input bit bad_s2, input int glitch);
    logic bits [13];
    int nb;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[1+i] = d[i];
    nb = 9;
    if (cfg_par_en) begin bits[nb] = (^d) ^ cfg_par_odd ^ bad_par; nb++; end
    bits[nb] = !bad_s1; nb++;
    if (cfg_two_stop) begin bits[nb] = !bad_s2; nb++; end
    push_d  = d;
    push_fe = bad_s1 | (cfg_two_stop & bad_s2);
    push_pe = cfg_par_en & bad_par;
    push_nz = (glitch >= 0);
    for (int b = 0; b < nb; b++)
      for (int s = 0; s < 16; s++)
        samp((b == glitch && s == 8) ? !bits[b] : bits[b], (b == nb - 1 && s == 9));
    repeat (24) samp(1'b1, 0);
  endtask

  task automatic rd_pulse();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic st_pulse();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R11 reset data_avail", data_avail, 0);
    chk("R11 reset ovr_err", ovr_err, 0);
    chk("R11 reset noise_err", noise_err, 0);
    chk("R11 reset irq", irq, 0);
    chk("R11 reset rd_data", rd_data, 0);
    rst_n = 1'b1;
    cmp_on = 1;

    // plain frame, no parity, one stop
    send_frame(8'hA5, 0, 0, 0, -1);
    @(negedge clk);
    chk("R1 word A5", rd_data, 8'hA5);
    chk("R12 word stored", data_avail, 1);
    rd_pulse(); @(negedge clk);
    chk("R1 empty after read", data_avail, 0);

    // even parity, correct
    cfg_par_en = 1; cfg_par_odd = 0;
    send_frame(8'h3C, 0, 0, 0, -1);
    @(negedge clk);
    chk("R8 even parity good", par_err, 0);
    rd_pulse();

    // odd parity, wrong
    cfg_par_odd = 1;
    send_frame(8'h81, 1, 0, 0, -1);
    @(negedge clk);
    chk("R8 odd parity bad", par_err, 1);
    chk("R8 word 81", rd_data, 8'h81);
    rd_pulse(); @(negedge clk);
    chk("R9 par_err gone with word", par_err, 0);

    // two stop bits, second bad, then good
    cfg_par_en = 0; cfg_two_stop = 1;
    send_frame(8'h55, 0, 0, 1, -1);
    @(negedge clk);
    chk("R7 second stop low", frame_err, 1);
    rd_pulse();
    send_frame(8'h66, 0, 0, 0, -1);
    @(negedge clk);
    chk("R7 two stops good", frame_err, 0);
    rd_pulse();

    // noise on a data bit, clear sequence order
    cfg_two_stop = 0; rie = 1;
    send_frame(8'h0F, 0, 0, 0, 4);
    @(negedge clk);
    chk("R2 voted word 0F", rd_data, 8'h0F);
    chk("R5 noise set", noise_err, 1);
    chk("R10 irq on word", irq, 1);
    rd_pulse(); @(negedge clk);
    chk("R6 noise kept without status read", noise_err, 1);
    chk("R10 noise alone no irq", irq, 0);
    st_pulse(); repeat (3) @(negedge clk);
    rd_pulse(); @(negedge clk);
    chk("R6 noise cleared by sequence", noise_err, 0);

    // noise on the start bit
    send_frame(8'hF0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R2 start glitch word F0", rd_data, 8'hF0);
    chk("R5 start glitch noise", noise_err, 1);
    st_pulse(); rd_pulse(); @(negedge clk);
    chk("R6 cleared", noise_err, 0);

    // short low pulse: false start
    for (int s = 0; s < 6; s++) samp(1'b0, 0);
    repeat (40) samp(1'b1, 0);
    @(negedge clk);
    chk("R3 false start ignored", data_avail, 0);

    // overrun
    send_frame(8'h11, 0, 1, 0, -1);
    send_frame(8'h22, 0, 0, 0, -1);
    send_frame(8'h33, 0, 0, 0, -1);
    @(negedge clk);
    chk("R4 overrun set", ovr_err, 1);
    chk("R4 head kept", rd_data, 8'h11);
    chk("R9 head frame_err", frame_err, 1);
    chk("R10 irq on overrun", irq, 1);
    rd_pulse(); @(negedge clk);
    chk("R6 overrun kept after lone read", ovr_err, 1);
    chk("R4 second word kept", rd_data, 8'h22);
    chk("R9 flag follows head", frame_err, 0);
    st_pulse(); repeat (2) @(negedge clk);
    rd_pulse(); @(negedge clk);
    chk("R6 overrun cleared", ovr_err, 0);
    chk("R4 third word dropped", data_avail, 0);

    // interrupt disabled
    rie = 0;
    send_frame(8'h44, 0, 0, 0, -1);
    @(negedge clk);
    chk("R10 irq masked", irq, 0);
    rd_pulse();

    repeat (4) @(negedge clk);
    cmp_on = 0;
    summary();
    $finish;
  end

endmodule